// File: doc/BRIEF.md
# Periodic Interval Timer

This peripheral produces a steady tick for system timekeeping. A fixed divide-by-16 prescaler feeds a 20-bit interval counter. The counter climbs from zero to a programmed period value and then returns to zero. Each return to zero is called a wrap. A wrap raises a status flag and increments a 12-bit wrap counter. When the interrupt enable is set, the flag drives a level interrupt. Software services a wrap by reading the acknowledging value register. That read returns the wrap count and the current count, then clears the flag and the wrap count. A mirror register returns the same word and clears nothing, so the current time can be sampled at any moment.

Clearing the enable does not stop the counter at once. A three-state controller handles this:

- **IDLE**: the counter is held at zero and the prescaler is held at zero.
- **RUN**: the counter advances normally.
- **DRAIN**: the enable has been cleared, and the counter finishes its current period.

The controller has four transitions:

- IDLE→RUN when the enable is set.
- RUN→DRAIN when the enable is cleared.
- DRAIN→RUN when the enable is set again.
- DRAIN→IDLE on the wrap that closes the period.

All registers are read through a simple bus. The read data is combinational while the read strobe is high. Any clearing caused by the read happens at the clock edge at which the strobe is sampled.

Top module: `tick_timer`

## Requirements
- R1: While the timer runs, the interval counter advances by exactly one every 16 clock cycles.
- R2: The control register is at offset 0x0. It holds the period value in bits 19:0, the run enable in bit 24 and the interrupt enable in bit 25. All its other bits read as zero, whatever was written to them.
- R3: The counter counts 0, 1, …, period value and then returns to 0. Two consecutive wraps are therefore (period value + 1) × 16 clock cycles apart.
- R4: Each wrap sets the status flag (offset 0x4, bit 0) and increments the wrap count.
- R5: A read at offset 0x8 returns the wrap count in bits 31:20 and the current count in bits 19:0. The same read clears the status flag and the wrap count.
- R6: A read at offset 0xC returns the same layout as offset 0x8 and changes no state.
- R7: When the run enable is cleared, the counter finishes the current period and wraps once more. It then stays at 0 and produces no further wraps.
- R8: The interrupt output is high exactly when both the status flag and the interrupt enable are set. With the interrupt enable clear, counting and status updates continue and the interrupt stays low.
- R9: An unacknowledged wrap count rolls over from 4095 to 0.
- R10: After reset, every register reads zero and the interrupt output is low. Writes to offsets 0x4, 0x8 and 0xC have no effect.
- R11: If a wrap and an acknowledging read occur in the same cycle, the wrap wins. The status flag stays set and the wrap count becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; enables read data and read side effects |
| bus_rdata | output | 32 | Read data, zero when bus_re is low |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrap and an acknowledging read can fall in the same clock edge. This is the one place where two of the block's functions compete for the status flag and the wrap count. The bench first locks onto the wrap phase with a fresh acknowledge right after a wrap. It then counts exactly one period and places the next read of offset 0x8 on the very edge of the following wrap. The outcome is judged through the status register and the mirror register: the flag must still be set and the wrap count must read 1, not 0 and not the earlier count plus one.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    // Controller states of the interval counter
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_state_t;

    // Register byte offsets
    localparam int OFS_MODE  = 0;
    localparam int OFS_FLAG  = 4;
    localparam int OFS_VALUE = 8;
    localparam int OFS_IMAGE = 12;

    // Control register bit positions
    localparam int EN_BIT  = 24;
    localparam int IEN_BIT = 25;

endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run & (&cnt_q);
endmodule

// File: rtl/tick_interval.sv
module tick_interval
    import tick_timer_pkg::*;
#(
    parameter int PIV_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [PIV_W-1:0] piv,
    output logic [PIV_W-1:0] cval,
    output logic             wrap,
    output logic             run,
    output run_state_t       state
);
    run_state_t       state_q, state_d;
    logic [PIV_W-1:0] cval_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = en ? ST_RUN : ST_IDLE;
            ST_RUN:   state_d = en ? ST_RUN : ST_DRAIN;
            ST_DRAIN: begin
                if (en) begin
                    state_d = ST_RUN;
                end else if (wrap) begin
                    state_d = ST_IDLE;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        run  = (state_q != ST_IDLE);
        wrap = tick & run & (cval_q >= piv);
    end

    // Interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cval_q <= '0;
        end else if (state_q == ST_IDLE) begin
            cval_q <= '0;
        end else if (tick) begin
            cval_q <= wrap ? '0 : cval_q + 1'b1;
        end
    end

    assign cval  = cval_q;
    assign state = state_q;
endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int PIV_W   = 20,
    parameter int PICNT_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_re,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               wrap,
    input  logic [PIV_W-1:0]   cval,
    output logic [PIV_W-1:0]   piv,
    output logic               en,
    output logic               ien,
    output logic               status,
    output logic [PICNT_W-1:0] picnt,
    output logic               ack_rd,
    output logic               img_rd
);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(OFS_VALUE);
    localparam logic [ADDR_W-1:0] A_IMAGE = ADDR_W'(OFS_IMAGE);

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    logic mode_wr;
    assign mode_wr = bus_we & (bus_addr == A_MODE);
    assign ack_rd  = bus_re & (bus_addr == A_VALUE);
    assign img_rd  = bus_re & (bus_addr == A_IMAGE);

    // Control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            piv <= '0;
            en  <= 1'b0;
            ien <= 1'b0;
        end else if (mode_wr) begin
            piv <= bus_wdata[PIV_W-1:0];
            en  <= bus_wdata[EN_BIT];
            ien <= bus_wdata[IEN_BIT];
        end
    end

    // Status flag and wrap count; a wrap takes priority over an acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= 1'b0;
            picnt  <= '0;
        end else if (wrap) begin
            status <= 1'b1;
            picnt  <= ack_rd ? PICNT_W'(1) : picnt + 1'b1;
        end else if (ack_rd) begin
            status <= 1'b0;
            picnt  <= '0;
        end
    end

    // Read decode
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (bus_addr)
                A_MODE: begin
                    bus_rdata[PIV_W-1:0] = piv;
                    bus_rdata[EN_BIT]    = en;
                    bus_rdata[IEN_BIT]   = ien;
                end
                A_FLAG:  bus_rdata[0] = status;
                A_VALUE, A_IMAGE: begin
                    bus_rdata[PIV_W-1:0]        = cval;
                    bus_rdata[PIV_W +: PICNT_W] = picnt;
                end
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int PIV_W   = 20,
    parameter int PICNT_W = 12,
    parameter int PRE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic               tick, wrap, run;
    logic               en, ien, status, ack_rd, img_rd;
    logic [PIV_W-1:0]   piv, cval;
    logic [PICNT_W-1:0] picnt;
    run_state_t         state;

    tick_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    tick_interval #(.PIV_W(PIV_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick),
        .piv   (piv),
        .cval  (cval),
        .wrap  (wrap),
        .run   (run),
        .state (state)
    );

    tick_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PIV_W   (PIV_W),
        .PICNT_W (PICNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .wrap      (wrap),
        .cval      (cval),
        .piv       (piv),
        .en        (en),
        .ien       (ien),
        .status    (status),
        .picnt     (picnt),
        .ack_rd    (ack_rd),
        .img_rd    (img_rd)
    );

    assign irq_o = status & ien;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int PIV_W   = 20,
    parameter int PICNT_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               wrap,
    input logic               ack_rd,
    input logic               img_rd,
    input logic               status,
    input logic [PICNT_W-1:0] picnt,
    input logic [PIV_W-1:0]   cval,
    input run_state_t         state,
    input logic               irq_o
);
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R1
    AST_WRAP_SETS:    assert property (@(posedge clk) disable iff (!rst_n) wrap |=> status); // R4
    AST_ACK_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n) (ack_rd && !wrap) |=> (!status && picnt == '0)); // R5
    AST_IMAGE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) (img_rd && !wrap) |=> ($stable(status) && $stable(picnt))); // R6
    AST_IDLE_ZERO:    assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IDLE) |-> (cval == '0)); // R7
    AST_IRQ_FLAG:     assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> status); // R8
    AST_WRAP_WINS:    assert property (@(posedge clk) disable iff (!rst_n) (ack_rd && wrap) |=> (status && picnt == PICNT_W'(1))); // R11
endmodule

bind tick_timer tick_timer_chk #(.PIV_W(PIV_W), .PICNT_W(PICNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wrap   (wrap),
    .ack_rd (ack_rd),
    .img_rd (img_rd),
    .status (status),
    .picnt  (picnt),
    .cval   (cval),
    .state  (state),
    .irq_o  (irq_o)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    tick_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic        is_wr;
        logic [3:0]  req;
        logic [3:0]  addr;
        logic [31:0] data;
    } vec_t;

    // Register-decode vectors, applied with the timer stopped
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd10, 4'h0, 32'h0000_0000},  // R10 reset value
        '{1'b0, 4'd10, 4'h4, 32'h0000_0000},  // R10
        '{1'b0, 4'd10, 4'h8, 32'h0000_0000},  // R10
        '{1'b0, 4'd10, 4'hC, 32'h0000_0000},  // R10
        '{1'b1, 4'd2,  4'h0, 32'hFCC0_ABCD},  // R2 unused bits written
        '{1'b0, 4'd2,  4'h0, 32'h0000_ABCD},  // R2 read back
        '{1'b1, 4'd10, 4'h4, 32'hFFFF_FFFF},  // R10 ignored write
        '{1'b1, 4'd10, 4'h8, 32'hFFFF_FFFF},  // R10
        '{1'b1, 4'd10, 4'hC, 32'hFFFF_FFFF},  // R10
        '{1'b0, 4'd10, 4'h0, 32'h0000_ABCD},  // R10 control untouched
        '{1'b0, 4'd10, 4'h4, 32'h0000_0000},  // R10 status untouched
        '{1'b0, 4'd10, 4'h8, 32'h0000_0000},  // R10
        '{1'b0, 4'd10, 4'hC, 32'h0000_0000}   // R10
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mode(input bit ie, input bit e, input logic [19:0] p);
        return (32'(ie) << 25) | (32'(e) << 24) | 32'(p);
    endfunction

    // All tasks start and end at a falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_re = 1'b0; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
    endtask

    task automatic ack_now(output logic [31:0] d);
        bus_we = 1'b0; bus_addr = 4'h8; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic poll(input int limit, output int n);
        bus_we = 1'b0; bus_addr = 4'h4; bus_re = 1'b1; n = 0;
        #1;
        while (!bus_rdata[0] && n < limit) begin
            @(negedge clk); #1; n++;
        end
        bus_re = 1'b0;
    endtask

    task automatic period(output int n);
        logic [31:0] d;
        poll(5000, n); ack_now(d);
        poll(5000, n); ack_now(d);
        poll(5000, n);
        n = n + 1;
    endtask

    initial begin
        logic [31:0] d, a, b;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 irq after reset", 32'(irq_o), 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) begin
                wr(VECS[i].addr, VECS[i].data);
            end else begin
                peek(VECS[i].addr, d);
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].data);
                @(negedge clk); bus_re = 1'b0;
            end
        end

        // R3: period length for two period values
        wr(4'h0, mode(1, 1, 20'd3));
        period(n);
        chk("R3 period piv=3", 32'(n), 32'd64);
        chk("R8 irq with flag and enable", 32'(irq_o), 32'd1);

        // R6: mirror reads leave state alone (one wrap since last acknowledge)
        peek(4'hC, a); @(negedge clk); #1 b = bus_rdata;
        chk("R6 image count first", 32'(a[31:20]), 32'd1);
        chk("R6 image count second", 32'(b[31:20]), 32'd1);
        peek(4'h4, d); chk("R6 status kept", d, 32'd1);
        @(negedge clk);
        ack_now(d);
        chk("R5 value read count", 32'(d[31:20]), 32'd1);
        peek(4'h4, d); chk("R5 status cleared", d, 32'd0);
        chk("R8 irq low after acknowledge", 32'(irq_o), 32'd0);
        bus_re = 1'b0;

        // R4: three unacknowledged wraps
        poll(5000, n); ack_now(d);
        repeat (192) @(negedge clk);
        peek(4'h4, d); chk("R4 status set", d, 32'd1);
        peek(4'hC, d); chk("R4 three wraps counted", 32'(d[31:20]), 32'd3);
        @(negedge clk);
        ack_now(d); chk("R5 acknowledge returns three", 32'(d[31:20]), 32'd3);
        peek(4'hC, d); chk("R5 count cleared", 32'(d[31:20]), 32'd0);
        peek(4'h4, d); chk("R5 flag cleared", d, 32'd0);
        @(negedge clk); bus_re = 1'b0;

        wr(4'h0, mode(1, 1, 20'd1));
        period(n);
        chk("R3 period piv=1", 32'(n), 32'd32);

        // R1: prescale ratio
        wr(4'h0, mode(1, 1, 20'd1000));
        peek(4'hC, a);
        repeat (160) @(negedge clk);
        #1 b = bus_rdata;
        chk("R1 ten counts in 160 cycles", 32'(b[19:0] - a[19:0]), 32'd10);
        bus_re = 1'b0;

        // R8: interrupt masked, counting continues
        wr(4'h0, mode(0, 1, 20'd3));
        ack_now(d);
        poll(5000, n);
        chk("R8 status still set while masked", 32'(n < 5000), 32'd1);
        chk("R8 irq masked", 32'(irq_o), 32'd0);

        // R11: wrap and acknowledge on the same edge
        poll(5000, n); ack_now(d);
        repeat (62) @(posedge clk);
        @(negedge clk);
        bus_addr = 4'h8; bus_re = 1'b1;
        @(negedge clk);
        peek(4'h4, d); chk("R11 flag survives", d, 32'd1);
        peek(4'hC, d); chk("R11 count is one", 32'(d[31:20]), 32'd1);
        @(negedge clk); bus_re = 1'b0;

        // R7: disable finishes the period
        wr(4'h0, mode(1, 1, 20'd3));
        ack_now(d);
        poll(5000, n); ack_now(d);
        wr(4'h0, mode(1, 0, 20'd3));
        poll(200, n);
        chk("R7 final wrap after disable", 32'(n < 200), 32'd1);
        ack_now(d);
        repeat (300) @(negedge clk);
        peek(4'hC, d); chk("R7 stopped at zero", d, 32'd0);
        peek(4'h4, d); chk("R7 no further wraps", d, 32'd0);
        @(negedge clk); bus_re = 1'b0;

        // R9: wrap-count rollover
        wr(4'h0, mode(0, 1, 20'd0));
        poll(5000, n); ack_now(d);
        repeat (65534) @(negedge clk);
        peek(4'hC, d); chk("R9 count at 4095", 32'(d[31:20]), 32'd4095);
        @(negedge clk); @(negedge clk);
        #1 d = bus_rdata; chk("R9 count rolled to 0", 32'(d[31:20]), 32'd0);
        peek(4'h4, d); chk("R9 flag set", d, 32'd1);
        @(negedge clk); bus_re = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung (actual=running expected=finished)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule